// File: doc/BRIEF.md
# Four-Line Interrupt Status and Mask Word

This block gathers four level-sensitive interrupt lines and eight single-cycle bus error events into one 32-bit status/control word. It drives a single request toward a parent interrupt controller. Each line has a sticky pending bit and an enable bit. Software acknowledges a line by writing a one to its pending bit.

The host reaches the word through a plain register port: a write enable, four byte strobes and 32 bits of write data. The current word is always visible on `rdata_o`. Pending bits share the top byte with enable bits, so a read-modify-write must put zeros in the pending positions. Otherwise it acknowledges lines by accident.

The same word carries enables for the error events, a 7-bit master priority field and a 4-bit ready-wait field. The block only stores the priority and ready-wait fields; it does not act on them.

Top module: `irq_word_unit`

## Requirements
- R1: After reset, every bit of `rdata_o` is 0 and `irq_o` is 0, so all lines and all error events start masked.
- R2: If line i (`line_i[i]`, with i=0 for the first line) is high at a clock edge, pending bit 28+i reads 1 from that edge on. It stays 1 after the line falls, until it is acknowledged.
- R3: A write with strobe 3 set clears each pending bit 31:28 whose data bit is 1. A pending bit whose data bit is 0 is left unchanged.
- R4: If a line is high in the same cycle as a write-one acknowledge of its pending bit, the pending bit stays 1.
- R5: Bits 25:22 enable lines 3 down to 0 (1 = unmasked). `irq_o` is 1 whenever some pending bit is 1 together with its enable bit.
- R6: Error enables sit at bits 27,26,21,20,19,18,17,16 for `err_i[7]` down to `err_i[0]` (1 = enabled). An `err_i` pulse whose enable is 1 makes `irq_o` high in the next cycle. A pulse whose enable is 0 has no effect on `irq_o`.
- R7: Bits 14:8 (priority) and 3:0 (ready wait) store whatever is written to them. Bits 15 and 7:4 always read 0.
- R8: A write of 0xF000 to the upper half (strobes 3 and 2 only, data bits 31:16 = 0xF000) clears all four pending bits and masks all four lines and all error events.
- R9: A write changes only the bytes whose strobe is set. A pending-bit acknowledge with strobe 3 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 4 | Level interrupt lines, bit 0 is the first line |
| err_i | input | 8 | Single-cycle error event pulses |
| wr_en_i | input | 1 | Write strobe for the word |
| be_i | input | 4 | Byte strobes, bit n covers data bits 8n+7:8n |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current contents of the word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Pending bits, enables and stored fields change at the clock edge that samples the line or the write. The change is seen on `rdata_o` one cycle after the stimulus is applied. `irq_o` follows the same edge for line sources, and follows the edge after the pulse for error events. The bench applies each stimulus just after a falling edge and advances its reference model at the next rising edge. It then compares `rdata_o` and `irq_o` at the following falling edge, once every cycle.

// File: rtl/irq_word_pkg.sv
package irq_word_pkg;
  localparam int unsigned N_LINES  = 4;
  localparam int unsigned N_ERR    = 8;
  localparam int unsigned PRIO_W   = 7;
  localparam int unsigned WAIT_W   = 4;
  // field positions decoded by software
  localparam int unsigned STS_LSB  = 28;
  localparam int unsigned LEN_LSB  = 22;
  localparam int unsigned EHI_LSB  = 26;
  localparam int unsigned ELO_LSB  = 16;
  localparam int unsigned PRIO_LSB = 8;
  localparam int unsigned WAIT_LSB = 0;
endpackage

// File: rtl/irq_word_line.sv
module irq_word_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  // set dominates acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (lvl_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_word_err.sv
module irq_word_err #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  output logic         hit_o
);
  logic hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= |(evt_i & en_i);
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/irq_word_cfg.sv
module irq_word_cfg
  import irq_word_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        be_i,
  input  logic [31:16]      wd_hi_i,
  input  logic [PRIO_W-1:0] wd_prio_i,
  input  logic [WAIT_W-1:0] wd_wait_i,
  output logic [N_LINES-1:0] len_o,
  output logic [N_ERR-1:0]  een_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [N_LINES-1:0] len_q;
  logic [N_ERR-1:0]   een_q;
  logic [PRIO_W-1:0]  prio_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [3:0]         we;

  assign we = be_i & {4{wr_en_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      een_q  <= '0;
      prio_q <= '0;
      wait_q <= '0;
    end else begin
      if (we[3]) begin
        een_q[7:6] <= wd_hi_i[EHI_LSB+1:EHI_LSB];
        len_q[3:2] <= wd_hi_i[LEN_LSB+3:LEN_LSB+2];
      end
      if (we[2]) begin
        len_q[1:0] <= wd_hi_i[LEN_LSB+1:LEN_LSB];
        een_q[5:0] <= wd_hi_i[ELO_LSB+5:ELO_LSB];
      end
      if (we[1]) prio_q <= wd_prio_i;
      if (we[0]) wait_q <= wd_wait_i;
    end
  end

  assign len_o  = len_q;
  assign een_o  = een_q;
  assign prio_o = prio_q;
  assign wait_o = wait_q;
endmodule

// File: rtl/irq_word_unit.sv
module irq_word_unit
  import irq_word_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  line_i,
  input  logic [7:0]  err_i,
  input  logic        wr_en_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic [N_LINES-1:0] pend, len, ack;
  logic [N_ERR-1:0]   een;
  logic [PRIO_W-1:0]  prio;
  logic [WAIT_W-1:0]  wait_v;
  logic               err_hit;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata_i[15], wdata_i[7:4]};
  assign ack = (wr_en_i && be_i[3]) ? wdata_i[STS_LSB+N_LINES-1:STS_LSB] : '0;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irq_word_line u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (line_i[g]),
      .ack_i (ack[g]),
      .pend_o(pend[g])
    );
  end

  irq_word_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .be_i     (be_i),
    .wd_hi_i  (wdata_i[31:16]),
    .wd_prio_i(wdata_i[PRIO_LSB+PRIO_W-1:PRIO_LSB]),
    .wd_wait_i(wdata_i[WAIT_LSB+WAIT_W-1:WAIT_LSB]),
    .len_o    (len),
    .een_o    (een),
    .prio_o   (prio),
    .wait_o   (wait_v)
  );

  irq_word_err #(.N(N_ERR)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (err_i),
    .en_i  (een),
    .hit_o (err_hit)
  );

  assign rdata_o = {pend, een[7:6], len, een[5:0], 1'b0, prio, 4'b0000, wait_v};
  assign irq_o   = (|(pend & len)) | err_hit;
endmodule

// File: rtl/irq_word_chk.sv
module irq_word_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  line_i,
  input logic [7:0]  err_i,
  input logic        wr_en_i,
  input logic [3:0]  be_i,
  input logic [31:28] wd_sts_i,
  input logic [31:0] rdata_o,
  input logic        irq_o
);
  logic [3:0] clr;
  logic [7:0] een;
  assign clr = (wr_en_i && be_i[3]) ? wd_sts_i : 4'd0;
  assign een = {rdata_o[27:26], rdata_o[21:16]};

  // R2: high line shows as pending next cycle
  a_r2_line_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i != 4'd0) |=> ((rdata_o[31:28] & $past(line_i)) == $past(line_i)));

  // R2: pending holds without acknowledge
  a_r2_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o[31:28] & ~clr) != 4'd0) |=>
      ((rdata_o[31:28] & $past(rdata_o[31:28] & ~clr)) == $past(rdata_o[31:28] & ~clr)));

  // R3, R4: acknowledge clears only where line is low
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr & ~line_i) != 4'd0) |=> ((rdata_o[31:28] & $past(clr & ~line_i)) == 4'd0));

  // R5
  a_r5_irq_on_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o[31:28] & rdata_o[25:22]) != 4'd0) |-> irq_o);

  // R6
  a_r6_err_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_i & een) != 8'd0) |=> irq_o);

  // R7
  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[15] == 1'b0) && (rdata_o[7:4] == 4'd0));
endmodule

bind irq_word_unit irq_word_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .line_i  (line_i),
  .err_i   (err_i),
  .wr_en_i (wr_en_i),
  .be_i    (be_i),
  .wd_sts_i(wdata_i[31:28]),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/irq_word_unit_tb_top.sv
`timescale 1ns/1ps
module irq_word_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  line = '0;
  logic [7:0]  err = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [3:0] m_sts = '0, m_len = '0, m_wait = '0;
  logic [7:0] m_een = '0;
  logic [6:0] m_prio = '0;
  logic       m_err = 1'b0;

  always #4 clk = ~clk;

  irq_word_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .err_i(err),
    .wr_en_i(we), .be_i(be), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] m_word();
    return {m_sts, m_een[7:6], m_len, m_een[5:0], 1'b0, m_prio, 4'b0000, m_wait};
  endfunction

  task automatic compare(input string tag);
    logic [31:0] ew;
    logic        ei;
    ew = m_word();
    ei = (|(m_sts & m_len)) | m_err;
    n_vec++;
    if (rdata !== ew || irq !== ei) begin
      n_bad++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", tag, rdata, irq, ew, ei);
    end
  endtask

  task automatic cyc(input logic [3:0] ln, input logic [7:0] er, input logic w,
                     input logic [3:0] b, input logic [31:0] d, input string tag);
    logic [3:0] clr, n_sts, n_len, n_wait;
    logic [7:0] n_een;
    logic [6:0] n_prio;
    logic       n_err;
    line = ln; err = er; we = w; be = b; wd = d;
    clr = (w && b[3]) ? d[31:28] : 4'd0;
    n_sts = (m_sts & ~clr) | ln;
    n_len = m_len; n_een = m_een; n_prio = m_prio; n_wait = m_wait;
    if (w && b[3]) begin n_een[7:6] = d[27:26]; n_len[3:2] = d[25:24]; end
    if (w && b[2]) begin n_len[1:0] = d[23:22]; n_een[5:0] = d[21:16]; end
    if (w && b[1]) n_prio = d[14:8];
    if (w && b[0]) n_wait = d[3:0];
    n_err = |(er & m_een);
    @(posedge clk);
    m_sts = n_sts; m_len = n_len; m_een = n_een; m_prio = n_prio; m_wait = n_wait; m_err = n_err;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(4'd0, 8'd0, 1'b0, 4'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle("R1");
    // R2: latch while masked, hold after line drops
    cyc(4'b0001, 8'd0, 1'b0, 4'd0, 32'd0, "R2");
    idle("R2");
    // R5: unmask first line
    cyc(4'd0, 8'd0, 1'b1, 4'b0100, 32'h0040_0000, "R5");
    // R3: acknowledge first line, write 0 to others
    cyc(4'd0, 8'd0, 1'b1, 4'b1000, 32'h1000_0000, "R3");
    // R9: acknowledge without strobe 3 ignored
    cyc(4'b0010, 8'd0, 1'b0, 4'd0, 32'd0, "R9");
    cyc(4'd0, 8'd0, 1'b1, 4'b0111, 32'hF000_0000, "R9");
    idle("R9");
    // R4: set beats acknowledge
    cyc(4'b0100, 8'd0, 1'b1, 4'b1000, 32'h4000_0000, "R4");
    idle("R4");
    // R6: enable event 0 and 7, pulse enabled and disabled events
    cyc(4'd0, 8'd0, 1'b1, 4'b1100, 32'h0801_0000, "R6");
    cyc(4'd0, 8'h01, 1'b0, 4'd0, 32'd0, "R6");
    idle("R6");
    cyc(4'd0, 8'h02, 1'b0, 4'd0, 32'd0, "R6");
    cyc(4'd0, 8'h80, 1'b0, 4'd0, 32'd0, "R6");
    idle("R6");
    // R7: stored fields and reserved bits
    cyc(4'd0, 8'd0, 1'b1, 4'b0011, 32'hFFFF_FFFF, "R7");
    cyc(4'd0, 8'd0, 1'b1, 4'b0011, 32'h0000_2A05, "R7");
    // R8: enable all, set all, then startup write
    cyc(4'b1111, 8'd0, 1'b1, 4'b1100, 32'h0FFF_0000, "R8");
    cyc(4'd0, 8'd0, 1'b1, 4'b1100, 32'hF000_0000, "R8");
    cyc(4'd0, 8'hFF, 1'b0, 4'd0, 32'd0, "R8");
    idle("R8");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic w;
      w = ($urandom_range(0, 3) == 0);
      cyc(4'($urandom), (($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'd0), w,
          4'($urandom), $urandom, "R5");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule